// File: doc/BRIEF.md
# Register Rename Stage with Reorder-Buffer Tags

This block sits between decode and the issue queue of an out-of-order core. It translates each instruction's register operands from the architectural name space into the tag space of a 16-slot reorder buffer. Each accepted instruction takes the next slot, in program order, and the slot index becomes its tag. A branch that writes no register still takes a slot. If the instruction has a destination, the map-table entry for that register then names the new tag, so later readers find the newest producer. Sources that no in-flight instruction produces are marked as reading the architectural register file.

Execution units report results by broadcasting the tag of the finished instruction. A renamed source whose producer has already broadcast is passed on as ready, and the issue queue takes its value from the reorder buffer. This also holds when the broadcast arrives in the cycle of renaming, or while the renamed instruction waits in the output register. Retirement removes the oldest slot once it has completed. The map entry of its destination goes back to architectural only when that entry still names the retiring tag. When all 16 slots are in flight, the stage stalls.

The output register is a two-state machine. In OUT_EMPTY no instruction is presented. In OUT_HELD one renamed instruction is presented. The transition LOAD (OUT_EMPTY or OUT_HELD to OUT_HELD) happens when an input is accepted. DRAIN (OUT_HELD to OUT_EMPTY) happens when the consumer takes the instruction and no new input is accepted. STALL (OUT_HELD to OUT_HELD) happens when the consumer is not ready.

Top module: `rn_rename`

## Requirements
- R1: After reset no output is valid, `in_ready` is high, the first accepted instruction receives tag 0, and every register reads as architectural (`*_renamed` = 0, `*_ready` = 1).
- R2: Every accepted instruction, including one with `in_has_dst` = 0, receives the tag one above the previous one, modulo 16 (after 15 comes 0).
- R3: A source with no in-flight producer is presented with `renamed` = 0 and `ready` = 1. A source with a producer is presented with `renamed` = 1 and the producer's tag.
- R4: An instruction with a destination makes later readers of that register see its tag. An instruction without a destination leaves the map unchanged.
- R5: A renamed source is presented with `ready` = 1 if its producer's tag was broadcast in an earlier cycle or in the cycle of renaming. A broadcast that arrives while the instruction is held in the output register sets that source's `ready` in place.
- R6: With 16 instructions in flight `in_ready` is low and no tag is allocated.
- R7: `ret_valid` retires the oldest in-flight instruction only when its tag has been broadcast. When the oldest instruction has not completed, `ret_valid` has no effect.
- R8: Retiring an instruction returns its destination's map entry to architectural only when that entry still holds the retiring tag. Otherwise the newer mapping stays.
- R9: While `out_valid` is high and `out_ready` is low, the presented instruction stays unchanged and `in_ready` is low.
- R10: When a source names the same register as the destination, the source takes the mapping that existed before this instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Stage accepts the instruction this cycle |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | 5 | Destination register index |
| in_src_a | input | 5 | First source register index |
| in_src_b | input | 5 | Second source register index |
| out_valid | output | 1 | Renamed instruction presented |
| out_ready | input | 1 | Issue queue takes the instruction |
| out_tag | output | 4 | Reorder-buffer slot of the instruction |
| out_has_dst | output | 1 | Instruction writes a register |
| out_dst | output | 5 | Destination register index |
| out_a_renamed | output | 1 | First source comes from an in-flight producer |
| out_a_tag | output | 4 | Producer tag of the first source |
| out_a_ready | output | 1 | First source value is available |
| out_b_renamed | output | 1 | Second source comes from an in-flight producer |
| out_b_tag | output | 4 | Producer tag of the second source |
| out_b_ready | output | 1 | Second source value is available |
| cmpl_valid | input | 1 | Completion broadcast present |
| cmpl_tag | input | 4 | Tag of the completed instruction |
| ret_valid | input | 1 | Request to retire the oldest instruction |

## Verification
Some properties are checked on every cycle. Tags follow acceptance order. No instruction is accepted while the buffer is full, and `in_ready` stays low whenever the output slot cannot drain. A held instruction stays frozen, and an architectural source is always reported ready. The directed scenarios cover the rest: correct producer tags across dependency chains, a source that names its own destination, and completion bypass in the renaming cycle and during a stall. They also check retirement that is refused for an incomplete head, the conditional clearing of map entries, and wrap-around of the tag counter after the buffer fills.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_HELD  = 1'b1
    } rn_out_state_e;

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NREG = 32,
    parameter int TW   = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    output logic          rd_a_vld,
    output logic [TW-1:0] rd_a_tag,
    input  logic [AW-1:0] rd_b_idx,
    output logic          rd_b_vld,
    output logic [TW-1:0] rd_b_tag,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_idx,
    input  logic [TW-1:0] clr_tag
);

    logic [NREG-1:0] ent_vld;
    logic [TW-1:0]   ent_tag [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[g] <= 1'b0;
                ent_tag[g] <= '0;
            end else if (wr_en && wr_idx == AW'(g)) begin
                ent_vld[g] <= 1'b1;
                ent_tag[g] <= wr_tag;
            end else if (clr_en && clr_idx == AW'(g) && ent_tag[g] == clr_tag) begin
                ent_vld[g] <= 1'b0;
            end
        end
    end

    assign rd_a_vld = ent_vld[rd_a_idx];
    assign rd_a_tag = ent_tag[rd_a_idx];
    assign rd_b_vld = ent_vld[rd_b_idx];
    assign rd_b_tag = ent_tag[rd_b_idx];

endmodule

// File: rtl/rn_rob_tags.sv
module rn_rob_tags #(
    parameter int DEPTH = 16,
    parameter int AW    = 5,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic             alloc_has_dst,
    input  logic [AW-1:0]    alloc_dst,
    output logic [TW-1:0]    tail_tag,
    output logic             full,
    input  logic             cmpl_valid,
    input  logic [TW-1:0]    cmpl_tag,
    input  logic             ret_req,
    output logic             ret_fire,
    output logic [TW-1:0]    head_tag,
    output logic             head_has_dst,
    output logic [AW-1:0]    head_dst,
    output logic [DEPTH-1:0] done_vec
);

    logic [TW:0]     count;
    logic [TW-1:0]   head_q;
    logic [TW-1:0]   tail_q;
    logic [DEPTH-1:0] slot_has_dst;
    logic [AW-1:0]   slot_dst [DEPTH];

    assign full     = (count == (TW+1)'(DEPTH));
    assign ret_fire = ret_req && (count != '0) && done_vec[head_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (alloc_en) tail_q <= tail_q + 1'b1;
            if (ret_fire) head_q <= head_q + 1'b1;
            case ({alloc_en, ret_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done_vec[g]     <= 1'b0;
                slot_has_dst[g] <= 1'b0;
                slot_dst[g]     <= '0;
            end else if (alloc_en && tail_q == TW'(g)) begin
                done_vec[g]     <= 1'b0;
                slot_has_dst[g] <= alloc_has_dst;
                slot_dst[g]     <= alloc_dst;
            end else if (cmpl_valid && cmpl_tag == TW'(g)) begin
                done_vec[g]     <= 1'b1;
            end
        end
    end

    assign tail_tag     = tail_q;
    assign head_tag     = head_q;
    assign head_has_dst = slot_has_dst[head_q];
    assign head_dst     = slot_dst[head_q];

endmodule

// File: rtl/rn_rename.sv
module rn_rename
    import rn_pkg::*;
#(
    parameter int ARCH_REGS = 32,
    parameter int ROB_DEPTH = 16,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int TW = $clog2(ROB_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_has_dst,
    input  logic [AW-1:0] in_dst,
    input  logic [AW-1:0] in_src_a,
    input  logic [AW-1:0] in_src_b,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [TW-1:0] out_tag,
    output logic          out_has_dst,
    output logic [AW-1:0] out_dst,
    output logic          out_a_renamed,
    output logic [TW-1:0] out_a_tag,
    output logic          out_a_ready,
    output logic          out_b_renamed,
    output logic [TW-1:0] out_b_tag,
    output logic          out_b_ready,
    input  logic          cmpl_valid,
    input  logic [TW-1:0] cmpl_tag,
    input  logic          ret_valid
);

    rn_out_state_e state_q, state_d;

    logic                 rob_full;
    logic [TW-1:0]        alloc_tag;
    logic                 ret_fire;
    logic [TW-1:0]        head_tag;
    logic                 head_has_dst;
    logic [AW-1:0]        head_dst;
    logic [ROB_DEPTH-1:0] done_vec;
    logic                 map_a_vld, map_b_vld;
    logic [TW-1:0]        map_a_tag, map_b_tag;
    logic                 in_fire;
    logic                 a_ready_now, b_ready_now;

    assign in_ready = !rob_full && (state_q == OUT_EMPTY || out_ready);
    assign in_fire  = in_valid && in_ready;

    rn_map_table #(.NREG(ARCH_REGS), .TW(TW)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (in_src_a),
        .rd_a_vld (map_a_vld),
        .rd_a_tag (map_a_tag),
        .rd_b_idx (in_src_b),
        .rd_b_vld (map_b_vld),
        .rd_b_tag (map_b_tag),
        .wr_en    (in_fire && in_has_dst),
        .wr_idx   (in_dst),
        .wr_tag   (alloc_tag),
        .clr_en   (ret_fire && head_has_dst),
        .clr_idx  (head_dst),
        .clr_tag  (head_tag)
    );

    rn_rob_tags #(.DEPTH(ROB_DEPTH), .AW(AW)) u_rob (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_en     (in_fire),
        .alloc_has_dst(in_has_dst),
        .alloc_dst    (in_dst),
        .tail_tag     (alloc_tag),
        .full         (rob_full),
        .cmpl_valid   (cmpl_valid),
        .cmpl_tag     (cmpl_tag),
        .ret_req      (ret_valid),
        .ret_fire     (ret_fire),
        .head_tag     (head_tag),
        .head_has_dst (head_has_dst),
        .head_dst     (head_dst),
        .done_vec     (done_vec)
    );

    // A source is available if it is architectural, already completed,
    // or completing in this very cycle.
    assign a_ready_now = !map_a_vld || done_vec[map_a_tag]
                         || (cmpl_valid && cmpl_tag == map_a_tag);
    assign b_ready_now = !map_b_vld || done_vec[map_b_tag]
                         || (cmpl_valid && cmpl_tag == map_b_tag);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: if (in_fire) state_d = OUT_HELD;
            OUT_HELD: begin
                if (in_fire)        state_d = OUT_HELD;
                else if (out_ready) state_d = OUT_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_tag       <= '0;
            out_has_dst   <= 1'b0;
            out_dst       <= '0;
            out_a_renamed <= 1'b0;
            out_a_tag     <= '0;
            out_a_ready   <= 1'b0;
            out_b_renamed <= 1'b0;
            out_b_tag     <= '0;
            out_b_ready   <= 1'b0;
        end else if (in_fire) begin
            out_tag       <= alloc_tag;
            out_has_dst   <= in_has_dst;
            out_dst       <= in_dst;
            out_a_renamed <= map_a_vld;
            out_a_tag     <= map_a_tag;
            out_a_ready   <= a_ready_now;
            out_b_renamed <= map_b_vld;
            out_b_tag     <= map_b_tag;
            out_b_ready   <= b_ready_now;
        end else if (state_q == OUT_HELD && cmpl_valid) begin
            if (out_a_renamed && cmpl_tag == out_a_tag) out_a_ready <= 1'b1;
            if (out_b_renamed && cmpl_tag == out_b_tag) out_b_ready <= 1'b1;
        end
    end

    assign out_valid = (state_q == OUT_HELD);

endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int TW = 4,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [TW-1:0] out_tag,
    input logic [AW-1:0] out_dst,
    input logic          out_a_renamed,
    input logic          out_a_ready,
    input logic          out_b_renamed,
    input logic          out_b_ready,
    input logic          rob_full
);

    logic [TW-1:0] exp_tag;

    always_ff @(posedge clk) begin
        if (!rst_n)                    exp_tag <= '0;
        else if (in_valid && in_ready) exp_tag <= exp_tag + 1'b1;
    end

    AST_TAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_tag == $past(exp_tag))); // R2

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        rob_full |-> !in_ready); // R6

    AST_ARCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_a_renamed) |-> out_a_ready); // R3

    AST_ARCH_READY_B: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_b_renamed) |-> out_b_ready); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_dst))); // R9

    AST_NO_TAKE_WHEN_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R9

endmodule

bind rn_rename rn_rename_chk #(.TW(TW), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_tag      (out_tag),
    .out_dst      (out_dst),
    .out_a_renamed(out_a_renamed),
    .out_a_ready  (out_a_ready),
    .out_b_renamed(out_b_renamed),
    .out_b_ready  (out_b_ready),
    .rob_full     (rob_full)
);

// File: tb/rn_rename_bench.sv
module rn_rename_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_has_dst = 1'b0;
    logic [4:0] in_dst = '0;
    logic [4:0] in_src_a = '0;
    logic [4:0] in_src_b = '0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [3:0] out_tag;
    logic       out_has_dst;
    logic [4:0] out_dst;
    logic       out_a_renamed;
    logic [3:0] out_a_tag;
    logic       out_a_ready;
    logic       out_b_renamed;
    logic [3:0] out_b_tag;
    logic       out_b_ready;
    logic       cmpl_valid = 1'b0;
    logic [3:0] cmpl_tag = '0;
    logic       ret_valid = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int exp_tag = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    rn_rename u_rn_rename (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_has_dst(in_has_dst),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
        .out_has_dst(out_has_dst), .out_dst(out_dst),
        .out_a_renamed(out_a_renamed), .out_a_tag(out_a_tag), .out_a_ready(out_a_ready),
        .out_b_renamed(out_b_renamed), .out_b_tag(out_b_tag), .out_b_ready(out_b_ready),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .ret_valid(ret_valid)
    );

    task automatic check_eq(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Drive one instruction at a falling edge; outputs are sampled at the next one.
    task automatic rename(bit has_dst, int dst, int sa, int sb);
        check_eq("R9 in_ready before rename", in_ready, 1);
        in_valid   = 1'b1;
        in_has_dst = has_dst;
        in_dst     = 5'(dst);
        in_src_a   = 5'(sa);
        in_src_b   = 5'(sb);
        @(negedge clk);
        in_valid = 1'b0;
        check_eq("R2 out_valid", out_valid, 1);
        check_eq("R2 tag order", out_tag, exp_tag);
        exp_tag = (exp_tag + 1) % 16;
    endtask

    task automatic complete(int t);
        cmpl_valid = 1'b1;
        cmpl_tag   = 4'(t);
        @(negedge clk);
        cmpl_valid = 1'b0;
    endtask

    task automatic retire();
        ret_valid = 1'b1;
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic t_reset();
        check_eq("R1 out_valid after reset", out_valid, 0);
        check_eq("R1 in_ready after reset", in_ready, 1);
    endtask

    task automatic t_no_dep();
        rename(1, 1, 2, 3);                                 // tag0
        check_eq("R1 first tag", out_tag, 0);
        check_eq("R3 src a architectural", out_a_renamed, 0);
        check_eq("R3 src a ready", out_a_ready, 1);
        check_eq("R1 src b architectural", out_b_renamed, 0);
        check_eq("R1 src b ready", out_b_ready, 1);
    endtask

    task automatic t_chain();
        rename(1, 4, 1, 0);                                 // tag1
        check_eq("R3 src a renamed", out_a_renamed, 1);
        check_eq("R3 src a tag", out_a_tag, 0);
        check_eq("R3 src a waiting", out_a_ready, 0);
        rename(1, 4, 4, 4);                                 // tag2
        check_eq("R10 self source tag", out_a_tag, 1);
        check_eq("R10 self source renamed", out_b_renamed, 1);
        rename(0, 9, 4, 2);                                 // tag3 branch
        check_eq("R4 newest producer", out_a_tag, 2);
        check_eq("R2 branch has no dst", out_has_dst, 0);
        rename(0, 0, 4, 2);                                 // tag4
        check_eq("R4 branch left map alone", out_a_tag, 2);
    endtask

    task automatic t_complete();
        complete(2);
        rename(0, 0, 4, 2);                                 // tag5
        check_eq("R5 completed producer ready", out_a_ready, 1);
        check_eq("R5 completed producer still renamed", out_a_renamed, 1);
        cmpl_valid = 1'b1;
        cmpl_tag   = 4'd0;
        rename(0, 0, 1, 2);                                 // tag6, same-cycle broadcast
        cmpl_valid = 1'b0;
        check_eq("R5 same-cycle bypass tag", out_a_tag, 0);
        check_eq("R5 same-cycle bypass ready", out_a_ready, 1);
    endtask

    task automatic t_backpressure();
        rename(1, 9, 0, 0);                                 // tag7
        @(negedge clk);
        out_ready = 1'b0;
        rename(0, 0, 9, 0);                                 // tag8 held
        check_eq("R5 waiting on tag7", out_a_ready, 0);
        check_eq("R9 in_ready low while held", in_ready, 0);
        @(negedge clk);
        check_eq("R9 held tag stable", out_tag, 8);
        check_eq("R9 still valid", out_valid, 1);
        complete(7);
        check_eq("R5 held source woken", out_a_ready, 1);
        check_eq("R9 tag unchanged after wake", out_tag, 8);
        out_ready = 1'b1;
        @(negedge clk);
        check_eq("R9 drained", out_valid, 0);
    endtask

    task automatic t_retire();
        retire();                                           // tag0 (dst1) leaves
        rename(0, 0, 1, 0);                                 // tag9
        check_eq("R8 mapping cleared", out_a_renamed, 0);
        complete(1);
        retire();                                           // tag1 (dst4, map holds tag2)
        rename(0, 0, 4, 0);                                 // tag10
        check_eq("R8 newer mapping kept", out_a_renamed, 1);
        check_eq("R8 newer mapping tag", out_a_tag, 2);
        retire();                                           // tag2 leaves, head tag3
    endtask

    task automatic t_full();
        for (int i = 0; i < 8; i++) rename(0, 0, 0, 0);     // tags 11..15,0,1,2
        @(negedge clk);
        check_eq("R6 stall when full", in_ready, 0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_eq("R6 nothing presented when full", out_valid, 0);
        retire();                                           // head tag3 not done
        check_eq("R7 incomplete head kept", in_ready, 0);
        complete(3);
        retire();
        check_eq("R7 completed head retired", in_ready, 1);
        rename(0, 0, 0, 0);
        check_eq("R2 wrap reuses slot", out_tag, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_dep();
        t_chain();
        t_complete();
        t_backpressure();
        t_retire();
        t_full();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule